// File: doc/BRIEF.md
# Truth-Table Logic and Arithmetic Unit

A purely combinational 16-bit operation unit for a small processor datapath. It receives a destination operand, a source operand, a 4-bit mode field, an operation-class bit and the stored carry flag. It returns an 18-bit word: 16 data bits, a carry bit and an overflow bit.

With the class bit clear, the mode field is a programmable truth table. Each destination/source bit pair picks one of the four mode bits, so any two-input bitwise function is one mode value. With the class bit set, the mode field selects one of four things: a precomputed shift result, an add, a subtract or a jump. A jump passes the incremented program address. Mode bit 0 decides whether the stored carry enters the add or subtract.

The shift datapath and the program-address incrementer sit outside this unit and arrive as inputs.

Top module: `truth_alu`

## Requirements
- R1: With `arith_i`=0, every data bit i of `res_o` equals `mode_i[2*dst_i[i] + src_i[i]]`.
- R2: With `arith_i`=0, `res_o[16]` (carry) and `res_o[17]` (overflow) are 0, whatever `carry_i` is.
- R3: With `arith_i`=1 and `mode_i[3]`=0, all 18 bits of `res_o` equal `shift_i`.
- R4: With `arith_i`=1 and `mode_i[3:1]`=100, `res_o[15:0]` is `dst_i + src_i + cin` modulo 2^16, and `res_o[16]` is the carry out of bit 15.
- R5: With `arith_i`=1 and `mode_i[3:1]`=101, `res_o[15:0]` is `dst_i - src_i - cin` modulo 2^16, and `res_o[16]` is a borrow: it is 1 exactly when `src_i + cin > dst_i`.
- R6: cin is `carry_i` AND `mode_i[0]`. With `mode_i[0]`=0, `carry_i` has no effect on the add or subtract result.
- R7: For an add, `res_o[17]` is 1 exactly when the two operand sign bits (bit 15) are equal and the sum sign differs from them.
- R8: For a subtract, `res_o[17]` is 1 exactly when the operand sign bits differ and the difference sign differs from the `dst_i` sign.
- R9: With `arith_i`=1 and `mode_i`=1111 (jump), `res_o[15:0]` equals `next_pc_i` and `res_o[17:16]` is 00.
- R10: With `arith_i`=1 and `mode_i` equal to 1100, 1101 or 1110, all 18 bits of `res_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dst_i | input | 16 | Destination operand (old destination register value) |
| src_i | input | 16 | Source operand |
| mode_i | input | 4 | Truth table (logic class) or operation select (arithmetic class) |
| arith_i | input | 1 | Operation class: 0 logic, 1 arithmetic/shift/jump |
| carry_i | input | 1 | Stored carry flag |
| shift_i | input | 18 | Precomputed shift result: {overflow, carry, data} |
| next_pc_i | input | 16 | Incremented program address used by a jump |
| res_o | output | 18 | Result: [17] overflow, [16] carry, [15:0] data |

## Verification
The truth-table path gets operand pairs in which every bit pair (0,0), (0,1), (1,0) and (1,1) occurs. Several table values are applied to them: constant 0, constant 1, AND, OR, XOR and copy-destination. A wrong table index order shows up as a swapped result, and an unused table bit shows up as a constant. The adder and subtracter get operands placed at the carry, borrow and signed-overflow edges (FFFF+1, 7FFF+1, 0-1, 8000-1, equal operands with carry-in). These separate the carry from the overflow and the borrow from a plain carry. Each is run with `carry_i` both gated and ungated by mode bit 0. Further cases cover the shift pass-through, the jump and the reserved mode values. In these cases, distinct patterns on `shift_i` and `next_pc_i` show which source drove the output.

// File: rtl/tlu_pkg.sv
package tlu_pkg;

    localparam int unsigned DATA_W = 16;
    localparam int unsigned MODE_W = 4;
    localparam int unsigned RES_W  = DATA_W + 2;

    typedef enum logic [2:0] {
        SEL_LOGIC,
        SEL_SHIFT,
        SEL_ADD,
        SEL_SUB,
        SEL_JUMP,
        SEL_ZERO
    } path_sel_e;

    typedef struct packed {
        logic              ovf;
        logic              cy;
        logic [DATA_W-1:0] data;
    } tlu_res_t;

    function automatic path_sel_e pick_path(input logic arith, input logic [MODE_W-1:0] m);
        path_sel_e sel;
        if (!arith)                  sel = SEL_LOGIC;
        else if (!m[3])              sel = SEL_SHIFT;
        else if (m[2:1] == 2'b00)    sel = SEL_ADD;
        else if (m[2:1] == 2'b01)    sel = SEL_SUB;
        else if (m == 4'b1111)       sel = SEL_JUMP;
        else                         sel = SEL_ZERO;
        return sel;
    endfunction

endpackage

// File: rtl/tlu_truth_table.sv
module tlu_truth_table #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] dst_i,
    input  logic [W-1:0] src_i,
    input  logic [3:0]   table_i,
    output logic [W-1:0] out_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] idx;
        assign idx      = {dst_i[i], src_i[i]};
        assign out_o[i] = table_i[idx];
    end
endmodule

// File: rtl/tlu_ripple.sv
module tlu_ripple #(
    parameter int unsigned W        = 16,
    parameter bit          SUBTRACT = 1'b0
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] val_o,
    output logic         cy_o,
    output logic         ovf_o
);
    localparam int unsigned MSB = W - 1;

    logic [W-1:0] opa;
    logic [W-1:0] z;
    logic [W:0]   c;

    assign opa  = SUBTRACT ? ~a_i : a_i;
    assign c[0] = cin_i;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign z[i]   = opa[i] ^ b_i[i] ^ c[i];
        assign c[i+1] = (opa[i] & b_i[i]) | (opa[i] & c[i]) | (b_i[i] & c[i]);
    end

    assign val_o = SUBTRACT ? ~z : z;
    assign cy_o  = c[W];

    if (SUBTRACT) begin : g_sub_ovf
        assign ovf_o = (a_i[MSB] ^ b_i[MSB]) & (val_o[MSB] ^ a_i[MSB]);
    end else begin : g_add_ovf
        assign ovf_o = ~(a_i[MSB] ^ b_i[MSB]) & (val_o[MSB] ^ a_i[MSB]);
    end
endmodule

// File: rtl/tlu_select.sv
module tlu_select
    import tlu_pkg::*;
(
    input  path_sel_e         sel_i,
    input  logic [DATA_W-1:0] logic_i,
    input  logic [RES_W-1:0]  shift_i,
    input  tlu_res_t          add_i,
    input  tlu_res_t          sub_i,
    input  logic [DATA_W-1:0] jump_i,
    output tlu_res_t          res_o
);
    always_comb begin
        res_o = '0;
        unique case (sel_i)
            SEL_LOGIC: res_o.data = logic_i;
            SEL_SHIFT: res_o      = tlu_res_t'(shift_i);
            SEL_ADD:   res_o      = add_i;
            SEL_SUB:   res_o      = sub_i;
            SEL_JUMP:  res_o.data = jump_i;
            default:   res_o      = '0;
        endcase
    end
endmodule

// File: rtl/truth_alu.sv
module truth_alu
    import tlu_pkg::*;
(
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              arith_i,
    input  logic              carry_i,
    input  logic [RES_W-1:0]  shift_i,
    input  logic [DATA_W-1:0] next_pc_i,
    output logic [RES_W-1:0]  res_o
);
    path_sel_e         sel;
    logic              cin;
    logic [DATA_W-1:0] logic_val;
    tlu_res_t          add_res;
    tlu_res_t          sub_res;
    tlu_res_t          fin;

    assign sel = pick_path(arith_i, mode_i);
    assign cin = carry_i & mode_i[0];

    tlu_truth_table #(.W(DATA_W)) u_tt (
        .dst_i   (dst_i),
        .src_i   (src_i),
        .table_i (mode_i),
        .out_o   (logic_val)
    );

    tlu_ripple #(.W(DATA_W), .SUBTRACT(1'b0)) u_add (
        .a_i   (dst_i),
        .b_i   (src_i),
        .cin_i (cin),
        .val_o (add_res.data),
        .cy_o  (add_res.cy),
        .ovf_o (add_res.ovf)
    );

    tlu_ripple #(.W(DATA_W), .SUBTRACT(1'b1)) u_sub (
        .a_i   (dst_i),
        .b_i   (src_i),
        .cin_i (cin),
        .val_o (sub_res.data),
        .cy_o  (sub_res.cy),
        .ovf_o (sub_res.ovf)
    );

    tlu_select u_sel (
        .sel_i   (sel),
        .logic_i (logic_val),
        .shift_i (shift_i),
        .add_i   (add_res),
        .sub_i   (sub_res),
        .jump_i  (next_pc_i),
        .res_o   (fin)
    );

    assign res_o = fin;
endmodule

// File: rtl/truth_alu_chk.sv
module truth_alu_chk
    import tlu_pkg::*;
(
    input logic [DATA_W-1:0] dst_i,
    input logic [DATA_W-1:0] src_i,
    input logic [MODE_W-1:0] mode_i,
    input logic              arith_i,
    input logic              carry_i,
    input logic [RES_W-1:0]  shift_i,
    input logic [DATA_W-1:0] next_pc_i,
    input logic [RES_W-1:0]  res_o
);
    localparam int unsigned MSB = DATA_W - 1;

    always_comb begin
        if (!arith_i && mode_i == 4'b0000)
            p_tt_zero_r1: assert (res_o[DATA_W-1:0] == '0) else $error("R1 table 0000");
        if (!arith_i && mode_i == 4'b1100)
            p_tt_copy_r1: assert (res_o[DATA_W-1:0] == dst_i) else $error("R1 table 1100");
        if (!arith_i)
            p_no_flags_r2: assert (res_o[RES_W-1:DATA_W] == 2'b00) else $error("R2 flags");
        if (arith_i && !mode_i[3])
            p_shift_pass_r3: assert (res_o == shift_i) else $error("R3 shift");
        if (arith_i && mode_i[3:1] == 3'b100 && !mode_i[0])
            p_add_nocin_r6: assert (res_o[DATA_W:0] == ({1'b0, dst_i} + {1'b0, src_i}))
                else $error("R6 carry leaked");
        if (arith_i && mode_i[3:1] == 3'b100)
            p_add_ovf_r7: assert (res_o[RES_W-1] ==
                ((dst_i[MSB] == src_i[MSB]) && (res_o[MSB] != dst_i[MSB]))) else $error("R7");
        if (arith_i && mode_i[3:1] == 3'b101)
            p_sub_ovf_r8: assert (res_o[RES_W-1] ==
                ((dst_i[MSB] != src_i[MSB]) && (res_o[MSB] != dst_i[MSB]))) else $error("R8");
        if (arith_i && mode_i == 4'b1111)
            p_jump_r9: assert (res_o == {2'b00, next_pc_i}) else $error("R9 jump");
        if (arith_i && mode_i[3:2] == 2'b11 && mode_i != 4'b1111)
            p_reserved_zero_r10: assert (res_o == '0) else $error("R10 reserved");
        if (carry_i && arith_i && mode_i[3:1] == 3'b101 && mode_i[0] && src_i == dst_i)
            p_borrow_r5: assert (res_o[DATA_W] == 1'b1) else $error("R5 borrow");
    end
endmodule

bind truth_alu truth_alu_chk u_chk (.*);

// File: tb/sim_truth_alu.sv
`timescale 1ns/1ps
module sim_truth_alu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] dst, src, npc;
    logic [3:0]  mode;
    logic        arith, cy;
    logic [17:0] sh;
    logic [17:0] res;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    truth_alu u0 (
        .dst_i(dst), .src_i(src), .mode_i(mode), .arith_i(arith),
        .carry_i(cy), .shift_i(sh), .next_pc_i(npc), .res_o(res)
    );

    function automatic logic [17:0] model(input logic [15:0] d, input logic [15:0] s,
                                          input logic [3:0] m, input logic a, input logic c,
                                          input logic [17:0] shv, input logic [15:0] pc);
        logic [15:0] o;
        int          ci, sd, ss, full;
        logic        sgn;
        if (!a) begin
            for (int i = 0; i < 16; i++) o[i] = m[(d[i] ? 2 : 0) + (s[i] ? 1 : 0)];
            return {2'b00, o};
        end
        if (m[3] == 1'b0) return shv;
        ci = (m[0] && c) ? 1 : 0;
        sd = int'(d); ss = int'(s);
        if (m[2:1] == 2'b00) begin
            full = sd + ss + ci;
            o = full[15:0];
            sgn = (d[15] == s[15]) && (o[15] != d[15]);
            return {sgn, full >= 65536, o};
        end
        if (m[2:1] == 2'b01) begin
            full = sd - ss - ci;
            o = full[15:0];
            sgn = (d[15] != s[15]) && (o[15] != d[15]);
            return {sgn, (ss + ci) > sd, o};
        end
        if (m == 4'b1111) return {2'b00, pc};
        return 18'h0;
    endfunction

    task automatic chk(input string tag, input logic [17:0] exp);
        n_run++;
        if (res !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %05h expected %05h", tag, res, exp);
        end
    endtask

    task automatic drive(input logic [15:0] d, input logic [15:0] s, input logic [3:0] m,
                         input logic a, input logic c);
        @(negedge clk);
        dst = d; src = s; mode = m; arith = a; cy = c;
        @(posedge clk);
        #1;
    endtask

    task automatic run_case(input string tag, input logic [15:0] d, input logic [15:0] s,
                            input logic [3:0] m, input logic a, input logic c);
        drive(d, s, m, a, c);
        chk(tag, model(d, s, m, a, c, sh, npc));
    endtask

    task automatic t_reset_state;
        drive(16'h0, 16'h0, 4'h0, 1'b0, 1'b0);
        chk("R1 reset-time idle", 18'h0);
    endtask

    task automatic t_truth_tables;
        // operands hold every bit pair (d,s) = 00,01,10,11
        run_case("R1 table AND",  16'hF0F0, 16'hCCCC, 4'b1000, 1'b0, 1'b0);
        chk("R1 AND literal", 18'h0C0C0);
        run_case("R1 table OR",   16'hF0F0, 16'hCCCC, 4'b1110, 1'b0, 1'b0);
        run_case("R1 table XOR",  16'hF0F0, 16'hCCCC, 4'b0110, 1'b0, 1'b0);
        chk("R1 XOR literal", 18'h03C3C);
        run_case("R1 table ones", 16'h1234, 16'h5678, 4'b1111, 1'b0, 1'b0);
        run_case("R1 table d&~s", 16'hF0F0, 16'hCCCC, 4'b0100, 1'b0, 1'b0);
        chk("R1 d&~s literal", 18'h03030);
        run_case("R2 carry ignored", 16'hFFFF, 16'hFFFF, 4'b1111, 1'b0, 1'b1);
        chk("R2 flags zero", 18'h0FFFF);
    endtask

    task automatic t_shift;
        sh = 18'h2A5C3;
        run_case("R3 shift pass", 16'h1111, 16'h2222, 4'b0101, 1'b1, 1'b1);
        chk("R3 shift literal", 18'h2A5C3);
        sh = 18'h1003C;
        run_case("R3 shift pass b", 16'h0, 16'h0, 4'b0010, 1'b1, 1'b0);
    endtask

    task automatic t_add;
        run_case("R4 add wrap", 16'hFFFF, 16'h0001, 4'b1000, 1'b1, 1'b0);
        chk("R4 add carry literal", 18'h10000);
        run_case("R7 add ovf", 16'h7FFF, 16'h0001, 4'b1000, 1'b1, 1'b0);
        chk("R7 add ovf literal", 18'h28000);
        run_case("R7 neg ovf", 16'h8000, 16'h8000, 4'b1000, 1'b1, 1'b0);
        chk("R7 neg ovf literal", 18'h30000);
        run_case("R6 cin used", 16'h0005, 16'h0003, 4'b1001, 1'b1, 1'b1);
        chk("R6 cin literal", 18'h00009);
        run_case("R6 cin gated", 16'h0005, 16'h0003, 4'b1000, 1'b1, 1'b1);
        chk("R6 gated literal", 18'h00008);
    endtask

    task automatic t_sub;
        run_case("R5 sub borrow", 16'h0000, 16'h0001, 4'b1010, 1'b1, 1'b0);
        chk("R5 borrow literal", 18'h1FFFF);
        run_case("R8 sub ovf", 16'h8000, 16'h0001, 4'b1010, 1'b1, 1'b0);
        chk("R8 sub ovf literal", 18'h27FFF);
        run_case("R5 sub cin", 16'h0005, 16'h0003, 4'b1011, 1'b1, 1'b1);
        chk("R5 cin literal", 18'h00001);
        run_case("R5 equal cin", 16'h0003, 16'h0003, 4'b1011, 1'b1, 1'b1);
        chk("R5 equal literal", 18'h1FFFF);
        run_case("R6 sub gated", 16'h0003, 16'h0003, 4'b1010, 1'b1, 1'b1);
        chk("R6 sub gated literal", 18'h00000);
    endtask

    task automatic t_jump_reserved;
        sh = 18'h3FFFF;
        npc = 16'hBEEF;
        run_case("R9 jump", 16'h1234, 16'h5678, 4'b1111, 1'b1, 1'b1);
        chk("R9 jump literal", 18'h0BEEF);
        run_case("R10 mode 1100", 16'hFFFF, 16'hFFFF, 4'b1100, 1'b1, 1'b1);
        chk("R10 1100 literal", 18'h0);
        run_case("R10 mode 1101", 16'hFFFF, 16'hFFFF, 4'b1101, 1'b1, 1'b1);
        run_case("R10 mode 1110", 16'hFFFF, 16'hFFFF, 4'b1110, 1'b1, 1'b1);
    endtask

    initial begin
        dst = '0; src = '0; mode = '0; arith = 1'b0; cy = 1'b0; sh = '0; npc = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_truth_tables();
        t_shift();
        t_add();
        t_sub();
        t_jump_reserved();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule